// File: doc/BRIEF.md
# Framed Serial Word Receiver

This block recovers parallel words from a three-wire serial stream made of a bit clock, a frame-sync line and a data line. All three arrive as ordinary inputs in the system clock domain. The block detects the chosen bit-clock edge itself and, on each such edge, samples the sync and data lines. A frame begins when the sync line becomes active. After a programmable delay of zero, one or two bit clocks, the following bits are shifted in most-significant bit first and grouped into words.

A frame takes one of two layouts. In the single-phase layout it carries 1 to 128 words of one length. In the dual-phase layout it carries exactly two words, one per phase, and each phase has its own length, for example a left/right audio pair. Each finished word is held on a valid/acknowledge output together with a phase bit and a marker for the first word of the frame. Two sticky flags record a word lost to overwrite and a sync pulse that arrived while a frame was still running.

Top module: `rxf_receiver`

## Requirements
- R1: The word-length codes `cfg_len0`/`cfg_len1` are decoded as follows: 0=8 bits, 1=12 bits, 2=16 bits, 3=20 bits, 4=24 bits, and 5, 6 or 7=32 bits. Bits arrive MSB first. The word appears right-justified in `rx_data`, and every bit above the word length is zero.
- R2: When `cfg_dual`=0, a frame holds `cfg_words_m1`+1 words (1 to 128), all of length `cfg_len0`. Every word has `rx_phase`=0, and `rx_first`=1 only on the first word of the frame.
- R3: When `cfg_dual`=1, a frame holds two words. The first has length `cfg_len0`, `rx_phase`=0 and `rx_first`=1. The second has length `cfg_len1`, `rx_phase`=1 and `rx_first`=0.
- R4: The first data bit is the one sampled `cfg_delay` sampling edges after the edge that detected the sync start. A delay value of 3 acts as 2.
- R5: With `cfg_sample_rise`=1 the lines are sampled on rising `bclk` edges; with 0 they are sampled on falling edges.
- R6: A sync start is a sampling edge at which `fsync` equals `cfg_fsync_high` after a sampling edge at which it did not.
- R7: `rx_valid`, `rx_data`, `rx_phase` and `rx_first` hold until `rx_ack` is high in a clock cycle with `rx_valid` set. That cycle clears `rx_valid` unless a new word completes in the same cycle.
- R8: If a word completes while `rx_valid` is high and `rx_ack` is low, the new word replaces the held one and `ovr_flag` sets and stays set until reset.
- R9: A sync start during a frame, including its delay bits, does not disturb that frame. It sets `sync_err_flag`, which stays set until reset.
- R10: While `rst_n` is low at a clock edge, every output is cleared to zero.
- R11: Bits sampled after the last word of a frame and before the next sync start produce no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_sample_rise | input | 1 | 1: sample on rising bclk, 0: on falling |
| cfg_fsync_high | input | 1 | Active level of fsync |
| cfg_delay | input | 2 | Data delay in bit clocks (0..2) |
| cfg_dual | input | 1 | 1: two-phase frame |
| cfg_words_m1 | input | 7 | Words per single-phase frame minus one |
| cfg_len0 | input | 3 | Word-length code, first phase |
| cfg_len1 | input | 3 | Word-length code, second phase |
| bclk | input | 1 | Serial bit clock |
| fsync | input | 1 | Frame-sync line |
| sdata | input | 1 | Serial data line |
| rx_ack | input | 1 | Consumer takes the held word |
| rx_valid | output | 1 | A word is held |
| rx_data | output | 32 | Received word, right-justified |
| rx_phase | output | 1 | 0 first phase, 1 second phase |
| rx_first | output | 1 | First word of its frame |
| ovr_flag | output | 1 | Sticky overwrite flag |
| sync_err_flag | output | 1 | Sticky unexpected-sync flag |

## Verification
The assertions assume the following about the inputs:
- `bclk` changes slowly enough that each level lasts at least two system clocks.
- `fsync` and `sdata` change only away from the sampling edge.
- The configuration inputs stay fixed while a frame is in progress.
- `rx_ack` is raised only while a word is held.

The stimulus keeps to these limits. It holds each `bclk` level for four system clocks and changes the data and sync lines together with the non-sampling edge. It reprograms the configuration only after a frame's trailing idle bits, and it acknowledges a word one clock after seeing it valid.

// File: rtl/rxf_pkg.sv
// Shared types and helpers for the framed serial receiver.
// Assumes a fixed 32-bit output word.
package rxf_pkg;

    localparam int DATA_W = 32;
    localparam int LEN_W  = 6;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WAIT   = 2'd1,
        ST_ACTIVE = 2'd2
    } rx_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              phase;
        logic              first;
    } rx_word_t;

    // Translate a 3-bit length code into a bit count.
    function automatic logic [LEN_W-1:0] word_len(input logic [2:0] code);
        case (code)
            3'd0:    word_len = 6'd8;
            3'd1:    word_len = 6'd12;
            3'd2:    word_len = 6'd16;
            3'd3:    word_len = 6'd20;
            3'd4:    word_len = 6'd24;
            default: word_len = 6'd32;
        endcase
    endfunction

endpackage

// File: rtl/rxf_edge.sv
// Registers the serial lines once and flags the selected bit-clock edge.
// Assumes bclk levels last at least two clk cycles and that fsync and
// sdata are stable around the sampling edge. The sampled sync level is
// normalised so that 1 always means active.
module rxf_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_rise,
    input  logic fsync_high,
    input  logic bclk,
    input  logic fsync,
    input  logic sdata,
    output logic ev,
    output logic fs_act,
    output logic sd
);
    logic bclk_d, bclk_dd, fs_d, sd_d;

    // Capture the lines and keep one older bclk sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_d  <= 1'b0;
            bclk_dd <= 1'b0;
            fs_d    <= 1'b0;
            sd_d    <= 1'b0;
        end else begin
            bclk_d  <= bclk;
            bclk_dd <= bclk_d;
            fs_d    <= fsync;
            sd_d    <= sdata;
        end
    end

    // Pick the configured edge and normalise the sync polarity.
    always_comb begin
        ev     = sample_rise ? (bclk_d & ~bclk_dd) : (~bclk_d & bclk_dd);
        fs_act = (fs_d == fsync_high);
        sd     = sd_d;
    end

endmodule

// File: rtl/rxf_deframer.sv
// Frame state machine and shifter. At each sampling event it detects a
// sync start, counts the data delay, shifts bits in MSB first and reports
// each finished word for one clk cycle on word_done. Assumes the
// configuration is static while a frame runs.
module rxf_deframer
    import rxf_pkg::*;
#(
    parameter int MAX_WORDS = 128,
    localparam int IDX_W    = $clog2(MAX_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev,
    input  logic             fs_act,
    input  logic             sd,
    input  logic             cfg_dual,
    input  logic [IDX_W-1:0] cfg_words_m1,
    input  logic [2:0]       cfg_len0,
    input  logic [2:0]       cfg_len1,
    input  logic [1:0]       cfg_delay,
    output logic             word_done,
    output rx_word_t         word,
    output logic             sync_err
);
    rx_state_t         st;
    logic              wl;
    logic [LEN_W-1:0]  bitcnt;
    logic [IDX_W-1:0]  widx;
    logic [DATA_W-1:0] shreg;
    logic              fs_prev;

    logic              start, take, last_word, cur_phase;
    logic [1:0]        dly;
    logic [LEN_W-1:0]  cur_len;
    logic [DATA_W-1:0] shift_nx;

    // Decode the sync start, the bit-take condition and the next shift value.
    always_comb begin
        dly       = (cfg_delay == 2'd3) ? 2'd2 : cfg_delay;
        start     = ev & fs_act & ~fs_prev;
        cur_phase = cfg_dual & widx[0];
        cur_len   = word_len(cur_phase ? cfg_len1 : cfg_len0);
        take      = ev & (((st == ST_IDLE) & start & (dly == 2'd0)) |
                          ((st == ST_WAIT) & ~wl) |
                          (st == ST_ACTIVE));
        last_word = cfg_dual ? (widx == IDX_W'(1)) : (widx == cfg_words_m1);
        shift_nx  = (bitcnt == '0) ? {{(DATA_W-1){1'b0}}, sd}
                                   : {shreg[DATA_W-2:0], sd};
        word_done = take & ((bitcnt + 6'd1) == cur_len);
        word.data  = shift_nx;
        word.phase = cur_phase;
        word.first = (widx == '0);
    end

    // Remember the sync level seen at the previous sampling event.
    always_ff @(posedge clk) begin
        if (!rst_n)  fs_prev <= 1'b0;
        else if (ev) fs_prev <= fs_act;
    end

    // Set the sticky flag for a sync start that arrives while a frame runs.
    always_ff @(posedge clk) begin
        if (!rst_n)                         sync_err <= 1'b0;
        else if (start && st != ST_IDLE)    sync_err <= 1'b1;
    end

    // Advance the frame state and the bit and word counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            wl     <= 1'b0;
            bitcnt <= '0;
            widx   <= '0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    st <= (dly == 2'd0) ? ST_ACTIVE : ST_WAIT;
                    wl <= (dly == 2'd2);
                end
                ST_WAIT: if (ev) begin
                    if (!wl) st <= ST_ACTIVE;
                    else     wl <= 1'b0;
                end
                default: ;
            endcase
            if (word_done) begin
                bitcnt <= '0;
                if (last_word) begin
                    widx <= '0;
                    st   <= ST_IDLE;
                end else begin
                    widx <= widx + IDX_W'(1);
                end
            end else if (take) begin
                bitcnt <= bitcnt + 6'd1;
            end
        end
    end

    // Shift register for the word being assembled.
    always_ff @(posedge clk) begin
        if (!rst_n)    shreg <= '0;
        else if (take) shreg <= shift_nx;
    end

    AST_BITCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        bitcnt < cur_len) else $error("bit count beyond word length"); // R1
    AST_DONE_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |-> (ev && st != ST_IDLE)) else $error("word done off event"); // R11
    AST_SYNCERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |=> sync_err) else $error("sync error flag dropped"); // R9
    AST_DUAL_TWO_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_dual |-> (widx <= IDX_W'(1))) else $error("dual frame word index"); // R3

endmodule

// File: rtl/rxf_outbuf.sv
// One-word holding register with a valid/acknowledge handshake. A newly
// loaded word replaces one that has not been acknowledged, and that event
// sets a sticky overwrite flag. Assumes ack is only raised while valid.
module rxf_outbuf
    import rxf_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  rx_word_t word_in,
    input  logic     ack,
    output logic     valid,
    output rx_word_t word_out,
    output logic     ovr
);
    // Hold the word until it is acknowledged; record any overwrite.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid    <= 1'b0;
            word_out <= '0;
            ovr      <= 1'b0;
        end else if (load) begin
            valid    <= 1'b1;
            word_out <= word_in;
            if (valid && !ack) ovr <= 1'b1;
        end else if (ack) begin
            valid <= 1'b0;
        end
    end

    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ack) |=> valid) else $error("valid dropped unacked"); // R7
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !load) |=> $stable(word_out)) else $error("held word changed"); // R7
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |=> ovr) else $error("overwrite flag dropped"); // R8
    AST_OVR_ON_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        (load && valid && !ack) |=> ovr) else $error("overwrite not flagged"); // R8

endmodule

// File: rtl/rxf_receiver.sv
// Top level of the framed serial receiver: edge detector, deframer and
// output holding register. Assumes all inputs are synchronous to clk and
// that configuration only changes between frames.
module rxf_receiver
    import rxf_pkg::*;
#(
    parameter int MAX_WORDS = 128
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_sample_rise,
    input  logic                         cfg_fsync_high,
    input  logic [1:0]                   cfg_delay,
    input  logic                         cfg_dual,
    input  logic [$clog2(MAX_WORDS)-1:0] cfg_words_m1,
    input  logic [2:0]                   cfg_len0,
    input  logic [2:0]                   cfg_len1,
    input  logic                         bclk,
    input  logic                         fsync,
    input  logic                         sdata,
    input  logic                         rx_ack,
    output logic                         rx_valid,
    output logic [DATA_W-1:0]            rx_data,
    output logic                         rx_phase,
    output logic                         rx_first,
    output logic                         ovr_flag,
    output logic                         sync_err_flag
);
    logic     ev, fs_act, sd, word_done;
    rx_word_t word_new, word_held;

    rxf_edge u_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_rise (cfg_sample_rise),
        .fsync_high  (cfg_fsync_high),
        .bclk        (bclk),
        .fsync       (fsync),
        .sdata       (sdata),
        .ev          (ev),
        .fs_act      (fs_act),
        .sd          (sd)
    );

    rxf_deframer #(.MAX_WORDS(MAX_WORDS)) u_deframer (
        .clk          (clk),
        .rst_n        (rst_n),
        .ev           (ev),
        .fs_act       (fs_act),
        .sd           (sd),
        .cfg_dual     (cfg_dual),
        .cfg_words_m1 (cfg_words_m1),
        .cfg_len0     (cfg_len0),
        .cfg_len1     (cfg_len1),
        .cfg_delay    (cfg_delay),
        .word_done    (word_done),
        .word         (word_new),
        .sync_err     (sync_err_flag)
    );

    rxf_outbuf u_outbuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (word_done),
        .word_in  (word_new),
        .ack      (rx_ack),
        .valid    (rx_valid),
        .word_out (word_held),
        .ovr      (ovr_flag)
    );

    // Drive the output fields from the held word.
    always_comb begin
        rx_data  = word_held.data;
        rx_phase = word_held.phase;
        rx_first = word_held.first;
    end

    AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ((rx_data >> word_len(rx_phase ? cfg_len1 : cfg_len0)) == '0))
        else $error("bits above word length set"); // R1
    AST_SINGLE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !cfg_dual) |-> !rx_phase) else $error("phase in single mode"); // R2
    AST_DUAL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && cfg_dual) |-> (rx_first == !rx_phase)) else $error("dual first marker"); // R3

endmodule

// File: tb/tb_rxf_receiver.sv
module tb_rxf_receiver;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_BIT   = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_sample_rise = 1'b1, cfg_fsync_high = 1'b1, cfg_dual = 1'b0;
    logic [1:0] cfg_delay = 2'd0;
    logic [6:0] cfg_words_m1 = 7'd0;
    logic [2:0] cfg_len0 = 3'd0, cfg_len1 = 3'd0;
    logic       bclk = 1'b0, fsync = 1'b0, sdata = 1'b0, rx_ack = 1'b0;
    logic        rx_valid, rx_phase, rx_first, ovr_flag, sync_err_flag;
    logic [31:0] rx_data;

    rxf_receiver dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct { logic [31:0] d; bit ph; bit fst; } exp_t;
    exp_t q[$];

    int    n_chk = 0, n_fail = 0;
    string cur_req = "R10";
    bit    hold_ack = 1'b0, finished = 1'b0;
    logic [31:0] lfsr = 32'hACE1_2468;

    // Behavioural reference state.
    int   m_st = 0, m_wl = 0, m_bits = 0, m_widx = 0;
    logic [31:0] m_acc = '0;
    bit   m_prev = 0, m_ufs = 0, m_ovr = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int tb_len(input logic [2:0] c);
        case (c)
            3'd0: return 8;  3'd1: return 12; 3'd2: return 16;
            3'd3: return 20; 3'd4: return 24; default: return 32;
        endcase
    endfunction

    // Reference behaviour at one sampling edge.
    task automatic model_edge(input bit act, input bit b);
        bit start, tk;
        int dl, nw, ln;
        start = act && !m_prev;
        m_prev = act;
        dl = (cfg_delay == 2'd3) ? 2 : int'(cfg_delay);
        tk = 0;
        if (start && m_st != 0) m_ufs = 1;
        if (m_st == 0) begin
            if (start) begin
                if (dl == 0) begin m_st = 2; tk = 1; end
                else begin m_st = 1; m_wl = dl - 1; end
            end
        end else if (m_st == 1) begin
            if (m_wl == 0) begin m_st = 2; tk = 1; end
            else m_wl--;
        end else tk = 1;
        if (tk) begin
            m_acc = (m_bits == 0) ? {31'b0, b} : {m_acc[30:0], b};
            m_bits++;
            ln = tb_len((cfg_dual && m_widx == 1) ? cfg_len1 : cfg_len0);
            nw = cfg_dual ? 2 : int'(cfg_words_m1) + 1;
            if (m_bits == ln) begin
                q.push_back('{d: m_acc, ph: cfg_dual && m_widx == 1, fst: m_widx == 0});
                m_bits = 0;
                m_widx++;
                if (m_widx == nw) begin m_widx = 0; m_st = 0; end
            end
        end
    endtask

    task automatic bit_period(input bit act, input bit b);
        @(negedge clk);
        bclk  = ~cfg_sample_rise;
        fsync = cfg_fsync_high ? act : ~act;
        sdata = b;
        repeat (HALF_BIT) @(negedge clk);
        bclk = cfg_sample_rise;
        model_edge(act, b);
        repeat (HALF_BIT) @(negedge clk);
    endtask

    task automatic send_frame(input int nw, input int ufs_at, input int trail);
        int total;
        if (!cfg_dual) cfg_words_m1 = 7'(nw - 1);
        total = cfg_dual ? tb_len(cfg_len0) + tb_len(cfg_len1) : nw * tb_len(cfg_len0);
        for (int p = 0; p < int'(cfg_delay) + total + trail; p++) begin
            bit_period(p == 0 || p == ufs_at, lfsr[0]);
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic frame_end_checks();
        check(q.size() == 0, cur_req, "words left undelivered", q.size(), 0);
        check(sync_err_flag == m_ufs, "R9", "sync_err_flag", sync_err_flag, m_ufs);
        check(ovr_flag == m_ovr, "R8", "ovr_flag", ovr_flag, m_ovr);
    endtask

    // Monitor: compare each delivered word with the reference, then acknowledge.
    always @(negedge clk) begin
        if (rx_ack) rx_ack = 1'b0;
        else if (rst_n && rx_valid && !hold_ack) begin
            if (q.size() == 0) begin
                check(0, "R11", "unexpected word", rx_data, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(rx_data == e.d, cur_req, "rx_data", rx_data, e.d);
                check(rx_phase == e.ph, cur_req, "rx_phase", rx_phase, e.ph);
                check(rx_first == e.fst, cur_req, "rx_first", rx_first, e.fst);
            end
            rx_ack = 1'b1;
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(0, cur_req, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        // R10: outputs cleared under reset
        check({rx_valid, rx_data, rx_phase, rx_first, ovr_flag, sync_err_flag} == '0,
              "R10", "reset outputs", {rx_valid, rx_data}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 R2 R4 R6: 16-bit, three words, delay 1, rising edge, active high
        cur_req = "R2"; cfg_len0 = 3'd2; cfg_delay = 2'd1;
        send_frame(3, -1, 3); frame_end_checks();
        // R4: delay 0 with 8-bit, then delay 2 with 32-bit; R11 idle bits follow
        cur_req = "R4"; cfg_len0 = 3'd0; cfg_delay = 2'd0;
        send_frame(1, -1, 12); frame_end_checks();
        cfg_len0 = 3'd5; cfg_delay = 2'd2;
        send_frame(2, -1, 40); frame_end_checks();
        // R5 R6: falling edge sampling, active-low sync, 12-bit words
        cur_req = "R5"; cfg_sample_rise = 1'b0; cfg_fsync_high = 1'b0;
        cfg_len0 = 3'd1; cfg_delay = 2'd1;
        send_frame(4, -1, 3); frame_end_checks();
        // R1: code 7 acts as 32 bits, code 3 is 20 bits
        cur_req = "R1"; cfg_len0 = 3'd7; send_frame(1, -1, 3); frame_end_checks();
        cfg_len0 = 3'd3; send_frame(2, -1, 3); frame_end_checks();
        // R3: dual phase 12/24 then 20/8
        cur_req = "R3"; cfg_sample_rise = 1'b1; cfg_fsync_high = 1'b1; cfg_dual = 1'b1;
        cfg_len0 = 3'd1; cfg_len1 = 3'd4; send_frame(2, -1, 3); frame_end_checks();
        cfg_len0 = 3'd3; cfg_len1 = 3'd0; cfg_delay = 2'd0;
        send_frame(2, -1, 3); frame_end_checks();
        // R2: maximum frame of 128 eight-bit words
        cur_req = "R2"; cfg_dual = 1'b0; cfg_len0 = 3'd0; cfg_delay = 2'd1;
        send_frame(128, -1, 3); frame_end_checks();
        // R9: sync pulse in mid-frame is ignored and flagged
        cur_req = "R9";
        check(sync_err_flag == 1'b0, "R9", "flag clear before", sync_err_flag, 0);
        cfg_len0 = 3'd2; send_frame(3, 20, 3); frame_end_checks();
        check(sync_err_flag == 1'b1, "R9", "flag set after", sync_err_flag, 1);
        // R7 R8: no acknowledge, three words overwrite, last one held
        cur_req = "R8"; hold_ack = 1'b1; cfg_len0 = 3'd0;
        send_frame(3, -1, 3);
        repeat (20) @(negedge clk);
        check(rx_valid == 1'b1, "R7", "valid held without ack", rx_valid, 1);
        check(q.size() == 3, "R8", "reference word count", q.size(), 3);
        if (q.size() > 0) begin
            check(rx_data == q[$].d, "R8", "newest word kept", rx_data, q[$].d);
            q = '{q[$]};
        end
        m_ovr = 1;
        check(ovr_flag == 1'b1, "R8", "ovr_flag set", ovr_flag, 1);
        hold_ack = 1'b0;
        repeat (6) @(negedge clk);
        check(rx_valid == 1'b0, "R7", "valid cleared by ack", rx_valid, 0);
        frame_end_checks();
        finish_run();
    end
endmodule